// File: doc/BRIEF.md
# Configurable DRAM Channel Interleave Mapper

This block sits between a frame-buffer client and a multi-channel DRAM controller. It takes a linear byte address and works out which physical DRAM channel holds that byte and where the byte sits inside that channel's own dense address range. Two 8-bit configuration words set how it does this. A sizing word gives the memory per channel, the channel count and a channel-reversal flag. A layout word picks either a contiguous split, with one block of memory per channel, or a two-region interleave. In the interleave, a low tiled region rotates across the channels in small chunks and the linear region above it rotates in larger chunks.

A request is a byte address qualified by a valid strobe. The answer comes back on the next clock as a registered channel index, an in-channel offset, an out-of-range flag and a matching valid strobe. Every address bit above the selected chunk size that is not used to pick the channel is shifted down into the offset, so each channel sees a gap-free range that starts at zero.

Top module: `ilv_chan_mapper`

## Requirements
- R1: Sizing bits 7:4 hold a per-channel size code. Codes 3 to 8 mean 2^(20+code) bytes (8 MB up to 256 MB). Every other code is treated as 8 MB.
- R2: Sizing bits 3:2 select the channel count: 2'b10 gives two channels and 2'b11 gives four. Both 2'b00 and the reserved code 2'b01 give a single channel.
- R3: When layout bit 7 is 0, the channel is the address divided by the per-channel size, and the offset is the address modulo the per-channel size.
- R4: When layout bit 7 is 1, the boundary between the tiled and linear regions is 4 MB shifted left by layout bits 6:5 (4, 8, 16 or 32 MB). An address equal to the boundary belongs to the linear region.
- R5: Below the boundary, the chunk that rotates across channels is 64 B when layout bit 4 is 0 and 128 B when it is 1.
- R6: At or above the boundary, the chunk is 1 KB, 2 KB, 4 KB or 1 MB for layout bits 3:2 equal to 00, 01, 10 or 11.
- R7: When layout bit 7 is 0, layout bits 6:2 have no effect on the outputs.
- R8: When sizing bit 0 is set, the most significant bit of the channel index is inverted. Two channels swap, and in four-channel mode logical 0,1,2,3 go to physical 2,3,0,1. The flag has no effect with one channel.
- R9: In interleave mode, for chunk size C and N channels, the channel is (addr/C) mod N and the offset is (addr/(C·N))·C + (addr mod C).
- R10: With a single channel, the channel output is 0 and the offset equals the input address, whatever the layout word.
- R11: The out-of-range output is 1 exactly when the address is at or above the per-channel size times the channel count. When it is 1, the channel and offset outputs are undefined.
- R12: The response valid is asserted on the clock after a request valid and is low otherwise. The response outputs hold their value while no request arrives. Reset clears the response valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| size_cfg | input | 8 | Sizing word: size code, channel count, unused width bit, reversal flag |
| map_cfg | input | 8 | Layout word: interleave enable, tile size, fine and coarse chunk select |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Linear byte address |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_chan | output | 2 | Physical channel index |
| rsp_offset | output | ADDR_W | Byte offset inside the channel |
| rsp_oor | output | 1 | Address beyond installed memory |

## Verification
The bench probes the addresses on either side of the tiled/linear boundary. A design that compares the boundary with the wrong sense would hand the last tiled chunk, or the first linear one, the wrong chunk size, and so the wrong channel. It drives reserved size codes and the reserved channel-count code, where a design that decoded them literally would report a wrong capacity or a phantom second channel. Last-byte and first-beyond addresses catch an off-by-one in the out-of-range compare. Reversal is tried in two-channel, four-channel and tiled modes, where inverting the low bit instead of the top bit would send quad traffic to the neighbouring channel.

// File: rtl/ilv_mapper_pkg.sv
// Shared constants, register layouts and decode helpers for the channel
// interleave mapper. Assumes byte addressing and at most four channels.
package ilv_mapper_pkg;

    localparam int MAX_CH_LG   = 2;   // log2 of the largest channel count
    localparam int MB_LG       = 20;  // log2 of one megabyte
    localparam int SZ_CODE_MIN = 3;   // smallest legal per-channel size code
    localparam int SZ_CODE_MAX = 8;   // largest legal per-channel size code
    localparam int TILE_LG_MIN = 22;  // log2 of the smallest tiled region (4 MB)
    localparam int FINE_LG_MIN = 6;   // log2 of the small tiled chunk (64 B)

    // Sizing word as seen on the size_cfg port.
    typedef struct packed {
        logic [3:0] size_code;
        logic [1:0] chan_cnt;
        logic       wide_bus;
        logic       reverse;
    } size_word_t;

    // Layout word as seen on the map_cfg port.
    typedef struct packed {
        logic       tiled;
        logic [1:0] tile_sz;
        logic       fine_sel;
        logic [1:0] coarse_sel;
        logic [1:0] spare;
    } map_word_t;

    // log2 of the linear-region chunk for a coarse select code.
    function automatic int coarse_lg(input logic [1:0] sel);
        case (sel)
            2'b00:   return 10;
            2'b01:   return 11;
            2'b10:   return 12;
            default: return 20;
        endcase
    endfunction

    // log2 of the channel count for a channel-count code.
    function automatic int chan_count_lg(input logic [1:0] cnt);
        case (cnt)
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/ilv_cfg_decode.sv
// Configuration decoder: turns the two configuration words into log2 sizes
// (per channel, total, tile boundary, fine and coarse chunk) and the channel
// count. Purely combinational; assumes SH_W can hold values up to 30.
module ilv_cfg_decode
    import ilv_mapper_pkg::*;
#(
    parameter int SH_W = 6
) (
    input  logic [7:0]      size_cfg,
    input  logic [7:0]      map_cfg,
    output logic [1:0]      chan_lg,
    output logic [SH_W-1:0] size_lg,
    output logic [SH_W-1:0] total_lg,
    output logic [SH_W-1:0] tile_lg,
    output logic [SH_W-1:0] fine_lg,
    output logic [SH_W-1:0] coarse_lg_o,
    output logic            tiled,
    output logic            reverse
);

    size_word_t sw;
    map_word_t  mw;
    logic       cfg_unused;

    assign sw = size_word_t'(size_cfg);
    assign mw = map_word_t'(map_cfg);
    // The width bit and spare layout bits do not affect address mapping.
    assign cfg_unused = ^{sw.wide_bus, mw.spare};

    // Decode sizes and granularities from the configuration fields.
    always_comb begin
        chan_lg = 2'(chan_count_lg(sw.chan_cnt));
        if (int'(sw.size_code) >= SZ_CODE_MIN && int'(sw.size_code) <= SZ_CODE_MAX)
            size_lg = SH_W'(MB_LG + int'(sw.size_code));
        else
            size_lg = SH_W'(MB_LG + SZ_CODE_MIN);
        total_lg    = size_lg + SH_W'(chan_lg);
        tile_lg     = SH_W'(TILE_LG_MIN + int'(mw.tile_sz));
        fine_lg     = SH_W'(FINE_LG_MIN + int'(mw.fine_sel));
        coarse_lg_o = SH_W'(coarse_lg(mw.coarse_sel));
        tiled       = mw.tiled;
        reverse     = sw.reverse;
    end

endmodule

// File: rtl/ilv_gran_select.sv
// Chunk-size selector: picks the log2 chunk size for one address. Contiguous
// mode uses the per-channel size as the chunk; interleave mode uses the fine
// chunk below the tile boundary and the coarse chunk at or above it.
module ilv_gran_select #(
    parameter int ADDR_W = 32,
    parameter int SH_W   = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              tiled,
    input  logic [SH_W-1:0]   size_lg,
    input  logic [SH_W-1:0]   tile_lg,
    input  logic [SH_W-1:0]   fine_lg,
    input  logic [SH_W-1:0]   coarse_lg,
    output logic [SH_W-1:0]   gran_lg
);

    logic in_tile;

    // An address is in the tiled region when no bit at or above the boundary is set.
    assign in_tile = ((addr >> tile_lg) == '0);

    // Choose the chunk for this address.
    always_comb begin
        if (!tiled)
            gran_lg = size_lg;
        else if (in_tile)
            gran_lg = fine_lg;
        else
            gran_lg = coarse_lg;
    end

endmodule

// File: rtl/ilv_squeeze.sv
// Channel-bit extractor for a fixed channel count 2^CH_LG: takes the CH_LG
// bits just above the chunk as the channel and closes the gap they leave to
// form a dense in-channel offset. Assumes gran_lg + CH_LG < ADDR_W.
module ilv_squeeze #(
    parameter int ADDR_W = 32,
    parameter int SH_W   = 6,
    parameter int CH_LG  = 1,
    parameter int CHAN_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SH_W-1:0]   gran_lg,
    output logic [CHAN_W-1:0] chan,
    output logic [ADDR_W-1:0] offset
);

    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] upper;
    logic [ADDR_W-1:0] above_chunk;

    // Offset: bits below the chunk kept, bits above the channel field moved down.
    always_comb begin
        low_mask    = (ADDR_W'(1) << gran_lg) - ADDR_W'(1);
        upper       = addr >> (gran_lg + SH_W'(CH_LG));
        offset      = (upper << gran_lg) | (addr & low_mask);
        above_chunk = addr >> gran_lg;
    end

    generate
        if (CH_LG == 0) begin : g_one
            // Single channel: nothing to select.
            assign chan = '0;
        end else begin : g_many
            // Channel field sits directly above the chunk.
            assign chan = CHAN_W'(above_chunk[CH_LG-1:0]);
        end
    endgenerate

endmodule

// File: rtl/ilv_chan_mapper.sv
// Top of the DRAM channel interleave mapper. Registers one mapping result per
// request: physical channel, dense in-channel offset and out-of-range flag.
// Assumes ADDR_W >= 31 so the largest configuration (1 GB) fits.
module ilv_chan_mapper
    import ilv_mapper_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        size_cfg,
    input  logic [7:0]        map_cfg,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_chan,
    output logic [ADDR_W-1:0] rsp_offset,
    output logic              rsp_oor
);

    localparam int SH_W   = $clog2(ADDR_W) + 1;
    localparam int CHAN_W = MAX_CH_LG;
    localparam int LANES  = MAX_CH_LG + 1;

    logic [1:0]        chan_lg;
    logic [SH_W-1:0]   size_lg, total_lg, tile_lg, fine_lg, coarse_lg_w, gran_lg;
    logic              tiled, reverse;
    logic [CHAN_W-1:0] lane_chan [LANES];
    logic [ADDR_W-1:0] lane_off  [LANES];
    logic [CHAN_W-1:0] sel_chan, rev_mask;
    logic [ADDR_W-1:0] sel_off;
    logic              beyond;

    ilv_cfg_decode #(.SH_W(SH_W)) i_decode (
        .size_cfg   (size_cfg),
        .map_cfg    (map_cfg),
        .chan_lg    (chan_lg),
        .size_lg    (size_lg),
        .total_lg   (total_lg),
        .tile_lg    (tile_lg),
        .fine_lg    (fine_lg),
        .coarse_lg_o(coarse_lg_w),
        .tiled      (tiled),
        .reverse    (reverse)
    );

    ilv_gran_select #(.ADDR_W(ADDR_W), .SH_W(SH_W)) i_gran (
        .addr     (req_addr),
        .tiled    (tiled),
        .size_lg  (size_lg),
        .tile_lg  (tile_lg),
        .fine_lg  (fine_lg),
        .coarse_lg(coarse_lg_w),
        .gran_lg  (gran_lg)
    );

    // One extractor lane per supported channel count.
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            ilv_squeeze #(
                .ADDR_W(ADDR_W), .SH_W(SH_W), .CH_LG(k), .CHAN_W(CHAN_W)
            ) i_squeeze (
                .addr   (req_addr),
                .gran_lg(gran_lg),
                .chan   (lane_chan[k]),
                .offset (lane_off[k])
            );
        end
    endgenerate

    // Pick the lane that matches the configured channel count.
    always_comb begin
        sel_chan = lane_chan[0];
        sel_off  = lane_off[0];
        for (int k = 1; k < LANES; k++) begin
            if (int'(chan_lg) == k) begin
                sel_chan = lane_chan[k];
                sel_off  = lane_off[k];
            end
        end
    end

    // Reversal inverts the most significant bit of the active channel field.
    always_comb begin
        if (reverse && chan_lg != 2'd0)
            rev_mask = CHAN_W'(1) << (chan_lg - 2'd1);
        else
            rev_mask = '0;
    end

    // Out of range when any bit at or above the total size is set.
    assign beyond = ((req_addr >> total_lg) != '0);

    // Result register: valid follows request, data held between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_chan   <= '0;
            rsp_offset <= '0;
            rsp_oor    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_chan   <= sel_chan ^ rev_mask;
                rsp_offset <= sel_off;
                rsp_oor    <= beyond;
            end
        end
    end

endmodule

// File: rtl/ilv_chan_mapper_chk.sv
// Assertion checker for the channel interleave mapper, bound to every instance.
module ilv_chan_mapper_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        size_cfg,
    input logic [7:0]        map_cfg,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [1:0]        rsp_chan,
    input logic [ADDR_W-1:0] rsp_offset,
    input logic              rsp_oor
);

    // R12: a request produces a response on the next clock.
    a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R12: no request, no response, and the outputs hold.
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_chan) && $stable(rsp_offset) && $stable(rsp_oor)));

    // R10: single channel passes the address straight through on channel 0.
    a_r10_single_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !size_cfg[3]) |=> (rsp_chan == 2'd0 && rsp_offset == $past(req_addr)));

    // R2: two-channel mode never names channel 2 or 3.
    a_r2_dual_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && size_cfg[3:2] == 2'b10) |=> !rsp_chan[1]);

    // R11: nothing above 1 GB can be installed.
    a_r11_beyond_max: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr >> 30) != '0) |=> rsp_oor);

    // R3: 8 MB x 4 contiguous: channel is address bits 24:23.
    a_r3_contig_quad: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !map_cfg[7] && size_cfg == 8'h3C && req_addr < ADDR_W'(32'h0200_0000))
        |=> (rsp_chan == $past(req_addr[24:23]) && !rsp_oor));

    // R8: 8 MB x 2 contiguous reversed: channel is the inverse of bit 23.
    a_r8_rev_dual: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !map_cfg[7] && size_cfg == 8'h39 && req_addr < ADDR_W'(32'h0100_0000))
        |=> (rsp_chan[0] == !$past(req_addr[23])));

endmodule

bind ilv_chan_mapper ilv_chan_mapper_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_cfg  (size_cfg),
    .map_cfg   (map_cfg),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_chan  (rsp_chan),
    .rsp_offset(rsp_offset),
    .rsp_oor   (rsp_oor)
);

// File: tb/test_ilv_chan_mapper.sv
`timescale 1ns/1ps
module test_ilv_chan_mapper;

    localparam int AW = 32;

    typedef struct {
        logic [1:0]    chan;
        logic [AW-1:0] off;
        logic          oor;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    size_cfg = 8'h00;
    logic [7:0]    map_cfg = 8'h00;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_chan;
    logic [AW-1:0] rsp_offset;
    logic          rsp_oor;

    int   n_checks = 0;
    int   n_fail = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    ilv_chan_mapper #(.ADDR_W(AW)) i_ilv_chan_mapper (
        .clk(clk), .rst_n(rst_n), .size_cfg(size_cfg), .map_cfg(map_cfg),
        .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_chan(rsp_chan), .rsp_offset(rsp_offset), .rsp_oor(rsp_oor)
    );

    // Reference model written as division and remainder on the requirements.
    function automatic exp_t model(input logic [7:0] sz, input logic [7:0] mp,
                                   input logic [AW-1:0] a, input string tag);
        exp_t      e;
        longint    per, n, chunk, bound, blk, ad;
        int        code;
        code  = int'(sz[7:4]);
        per   = (code >= 3 && code <= 8) ? (64'd1 << (20 + code)) : (64'd1 << 23);
        n     = (sz[3:2] == 2'b10) ? 2 : (sz[3:2] == 2'b11) ? 4 : 1;
        ad    = longint'(a);
        e.tag = tag;
        e.oor = (ad >= per * n);
        if (n == 1) begin
            e.chan = 2'd0;
            e.off  = a;
        end else begin
            if (!mp[7]) chunk = per;
            else begin
                bound = 64'd4194304 << mp[6:5];
                if (ad < bound) chunk = mp[4] ? 128 : 64;
                else case (mp[3:2])
                    2'b00: chunk = 1024;
                    2'b01: chunk = 2048;
                    2'b10: chunk = 4096;
                    default: chunk = 1048576;
                endcase
            end
            blk    = ad / chunk;
            e.chan = 2'(blk % n);
            e.off  = AW'((blk / n) * chunk + ad % chunk);
            if (sz[0]) e.chan = e.chan ^ 2'(n / 2);
        end
        return e;
    endfunction

    // Driver: apply one request and queue its expected response.
    task automatic send(input logic [7:0] sz, input logic [7:0] mp,
                        input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        size_cfg  = sz;
        map_cfg   = mp;
        req_addr  = a;
        req_valid = 1'b1;
        sb.push_back(model(sz, mp, a, tag));
    endtask

    // Driver: apply one request and also check the model against a hand value.
    task automatic send_known(input logic [7:0] sz, input logic [7:0] mp,
                              input logic [AW-1:0] a, input logic [1:0] ch,
                              input logic [AW-1:0] off, input string tag);
        exp_t e;
        e = model(sz, mp, a, tag);
        n_checks++;
        if (e.chan !== ch || e.off !== off) begin
            n_fail++;
            $display("FAIL %s hand value: actual chan %0d off %h expected chan %0d off %h",
                     tag, e.chan, e.off, ch, off);
        end
        send(sz, mp, a, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pop and compare each response away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_checks++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R12 unexpected response: actual valid 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_oor !== e.oor ||
                    (!e.oor && (rsp_chan !== e.chan || rsp_offset !== e.off))) begin
                    n_fail++;
                    $display("FAIL %s: actual chan %0d off %h oor %0b expected chan %0d off %h oor %0b",
                             e.tag, rsp_chan, rsp_offset, rsp_oor, e.chan, e.off, e.oor);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [1:0]    h_chan;
        logic [AW-1:0] h_off;
        logic          h_oor;
        repeat (3) @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 reset: actual valid %0b expected 0", rsp_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R10: single channel, any layout word.
        send_known(8'h30, 8'h9C, 32'h0012_3456, 2'd0, 32'h0012_3456, "R10 single tiled word");
        send_known(8'h30, 8'h00, 32'h007F_FFC1, 2'd0, 32'h007F_FFC1, "R10 single contig");
        // R2: reserved count 01 is one channel; R11 edges.
        send_known(8'h34, 8'h80, 32'h007F_FFFF, 2'd0, 32'h007F_FFFF, "R2 reserved count");
        send(8'h34, 8'h80, 32'h0080_0000, "R11 single first beyond");
        // R3/R1: 32 MB x 2 contiguous.
        send_known(8'h58, 8'h00, 32'h01FF_FFFF, 2'd0, 32'h01FF_FFFF, "R3 dual last of ch0");
        send_known(8'h58, 8'h00, 32'h0200_0000, 2'd1, 32'h0000_0000, "R3 dual first of ch1");
        send(8'h58, 8'h00, 32'h0400_0000, "R11 dual first beyond");
        send_known(8'h58, 8'h00, 32'h03FF_FFFF, 2'd1, 32'h01FF_FFFF, "R11 dual last byte");
        // R3/R7: 16 MB x 4, granularity fields set but unused.
        send_known(8'h4C, 8'h00, 32'h0234_5678, 2'd2, 32'h0034_5678, "R3 quad contig");
        send_known(8'h4C, 8'h7C, 32'h0234_5678, 2'd2, 32'h0034_5678, "R7 gran ignored");
        send_known(8'h4C, 8'h7C, 32'h03FF_FFFF, 2'd3, 32'h00FF_FFFF, "R7 gran ignored top");
        // R1: reserved size codes fall back to 8 MB; code 8 is 256 MB.
        send_known(8'h98, 8'h00, 32'h0080_0000, 2'd1, 32'h0000_0000, "R1 code 9 is 8MB");
        send(8'h98, 8'h00, 32'h0100_0000, "R1 code 9 beyond");
        send(8'h28, 8'h00, 32'h0100_0000, "R1 code 2 beyond");
        send_known(8'h80, 8'h00, 32'h0FFF_FFFF, 2'd0, 32'h0FFF_FFFF, "R1 code 8 last");
        send(8'h80, 8'h00, 32'h1000_0000, "R1 code 8 beyond");
        send(8'h8C, 8'h00, 32'h3FFF_FFFF, "R1 R11 max quad last");
        // R8: reversal in contiguous dual/quad and single.
        send_known(8'h4D, 8'h00, 32'h0234_5678, 2'd0, 32'h0034_5678, "R8 quad reverse");
        send_known(8'h59, 8'h00, 32'h0000_0100, 2'd1, 32'h0000_0100, "R8 dual reverse");
        send_known(8'h31, 8'h80, 32'h0000_0040, 2'd0, 32'h0000_0040, "R8 single unaffected");
        // R4/R5/R9: 64 MB x 4, tiled boundary 4 MB.
        send_known(8'h6C, 8'h80, 32'h0000_0040, 2'd1, 32'h0000_0000, "R5 fine 64 ch1");
        send_known(8'h6C, 8'h80, 32'h0000_01C5, 2'd3, 32'h0000_0045, "R9 fine 64 dense");
        send_known(8'h6C, 8'h90, 32'h0000_0245, 2'd0, 32'h0000_00C5, "R5 fine 128");
        send_known(8'h6C, 8'h80, 32'h003F_FFC0, 2'd3, 32'h000F_FFC0, "R4 last tiled chunk");
        send_known(8'h6C, 8'h80, 32'h0040_0000, 2'd0, 32'h0010_0000, "R4 boundary is linear");
        send_known(8'h6C, 8'h80, 32'h0040_0410, 2'd1, 32'h0010_0010, "R6 coarse 1K");
        // R6: other coarse chunks.
        send(8'h6C, 8'h84, 32'h04A0_0810, "R6 coarse 2K");
        send(8'h6C, 8'h88, 32'h04A0_1810, "R6 coarse 4K");
        send_known(8'h6C, 8'h8C, 32'h0050_0010, 2'd1, 32'h0010_0010, "R6 coarse 1M");
        // R4: larger tile sizes move the boundary.
        send(8'h6C, 8'hA0, 32'h007F_FFC0, "R4 8MB tile last fine");
        send(8'h6C, 8'hA0, 32'h0080_0400, "R4 8MB tile first coarse");
        send(8'h6C, 8'hC0, 32'h00FF_FF80, "R4 16MB tile last fine");
        send_known(8'h6C, 8'hE0, 32'h0100_0040, 2'd1, 32'h0040_0000, "R4 32MB tile fine");
        send(8'h6C, 8'hE0, 32'h0200_0000, "R4 32MB tile boundary");
        // R8/R9: reversal in tiled quad and tiled dual.
        send_known(8'h6D, 8'h80, 32'h0000_0040, 2'd3, 32'h0000_0000, "R8 tiled quad reverse");
        send(8'h59, 8'h94, 32'h0123_4567, "R8 tiled dual reverse");
        send(8'h5B, 8'h98, 32'h02A0_3F00, "R9 dual coarse 4K");
        idle();

        // R12: outputs hold while idle.
        @(negedge clk);
        h_chan = rsp_chan; h_off = rsp_offset; h_oor = rsp_oor;
        repeat (4) @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_chan !== h_chan || rsp_offset !== h_off || rsp_oor !== h_oor) begin
            n_fail++;
            $display("FAIL R12 hold: actual valid %0b chan %0d off %h expected valid 0 chan %0d off %h",
                     rsp_valid, rsp_chan, rsp_offset, h_chan, h_off);
        end

        // R12: gapped requests.
        send(8'h3C, 8'h00, 32'h01AB_CDEF, "R12 gapped 1");
        idle();
        send(8'h3C, 8'h00, 32'h0123_0000, "R12 gapped 2");
        idle();
        repeat (3) @(negedge clk);
        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R12 missing responses: actual %0d pending expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule